// File: doc/BRIEF.md
# CRC-Checked Register Target Engine

This block is the byte-level back end of a bus target that owns a 64-byte register bank. A bit-level front end handles the serial bus. It passes this block start and stop events, an address-match strobe with the read/write direction, each received byte, and a request for each byte it must transmit. Every access begins with a pointer byte. Bits [5:0] of the pointer select the first register, and bits [7:6] give the number of data bytes to move.

With `CRC_EN=1`, every transfer is protected by a CRC-8. The CRC starts with the 8-bit bus address byte, which is the 7-bit `TARGET_ADDR` followed by the direction bit. It then covers the pointer byte and the data bytes.

Writes go into a four-byte staging buffer. The buffer is copied into the bank only when the write ends with a matching CRC byte and exactly one trailing filler byte. Any other ending discards the staged data and raises a sticky error flag.

Reads stream the requested bytes and then the CRC. Any further requests get 0xFF.

With `CRC_EN=0`, the bank is a plain incrementing byte store with no length field and no CRC.

Top module: `crcreg_target`

## Requirements
- R1: The CRC is CRC-8 with polynomial 0x07, processed MSB first, starting from 0x00, with no final XOR. Its first input byte is {TARGET_ADDR, rw}, where rw=0 for a write and rw=1 for a read.
- R2: In the pointer byte, bits [5:0] give the start register and bits [7:6] give the data length. Codes 00, 01, 10 and 11 mean 1, 2, 3 and 4 bytes.
- R3: A correct write stores its data bytes in consecutive registers from the start register, wrapping modulo 64. The store happens at the stop or repeated start that ends the write.
- R4: A write whose CRC byte differs from the CRC of address byte, pointer and data changes no register and sets `crc_err`.
- R5: A write whose byte count after the pointer is not data + CRC + filler changes no register and sets `crc_err`. A missing filler byte is one such case.
- R6: The value of the filler byte has no effect on the stored data or on `crc_err`.
- R7: A read returns the length-encoded number of bytes from consecutive registers (wrapping), then the CRC over {TARGET_ADDR,1}, the pointer and those bytes.
- R8: Every byte requested after the CRC byte of a read is 0xFF.
- R9: After reset, all registers, `tx_data` and `crc_err` are 0. `crc_err`, once set, stays set until reset.
- R10: A write that carries only a pointer byte and is then ended sets the pointer. It raises no error.
- R11: With CRC_EN=0, the bytes after the pointer are stored one by one at incrementing addresses (start = pointer bits [5:0], wrapping modulo 64). A read then streams registers from the pointer with no CRC byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Start or repeated-start seen (one-cycle pulse) |
| bus_stop | input | 1 | Stop seen (one-cycle pulse) |
| addr_match | input | 1 | Own bus address received (one-cycle pulse) |
| addr_rw | input | 1 | Direction with addr_match: 1 = read, 0 = write |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Front end needs the next byte to send |
| tx_data | output | 8 | Byte to send, loaded on the edge that samples tx_req |
| crc_err | output | 1 | Sticky flag for a rejected write |

## Verification
The bench builds two copies side by side. One has `CRC_EN=1`, which makes all four length codes, a bad CRC, a missing filler byte, a read past the CRC byte and register wrap at the top of the bank reachable. The other has `CRC_EN=0`, which exercises the plain streaming path, including wrap across address 63. Both use `TARGET_ADDR=7'h2C`, so the bench's own CRC model must include the 0x58/0x59 address bytes for every expected CRC to come out right.

// File: rtl/crcreg_pkg.sv
// Shared constants, phase type and CRC-8 step function for the register target.
// Assumes MSB-first CRC-8, polynomial 0x07, no reflection, no final XOR.
package crcreg_pkg;
    localparam int PTR_ADDR_BITS = 6;
    localparam int LEN_BITS      = 2;
    localparam int REG_DEPTH     = 1 << PTR_ADDR_BITS;
    localparam int MAX_XFER      = 1 << LEN_BITS;
    localparam logic [7:0] CRC_POLY = 8'h07;

    typedef enum logic [1:0] {PH_IDLE, PH_WR, PH_RD} phase_t;

    // One byte of CRC-8 update.
    function automatic logic [7:0] crc8_next(input logic [7:0] crc_in, input logic [7:0] data);
        logic [7:0] r;
        r = crc_in ^ data;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/crcreg_crc8_step.sv
// Combinational single-byte CRC-8 update.
// Assumes the caller registers the result; no state inside.
module crcreg_crc8_step (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    // Fold one byte into the running remainder.
    always_comb crc_out = crcreg_pkg::crc8_next(crc_in, data_in);
endmodule

// File: rtl/crcreg_regfile.sv
// Byte register bank with a multi-lane write port and one combinational read port.
// Lane l writes entry (wbase + l) mod DEPTH; assumes LANES <= DEPTH so lanes never collide.
module crcreg_regfile #(
    parameter int DEPTH = 64,
    parameter int LANES = 4,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0]           we,
    input  logic [AW-1:0]              wbase,
    input  logic [LANES-1:0][DW-1:0]   wdata,
    input  logic [AW-1:0]              raddr,
    output logic [DW-1:0]              rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [LANES-1:0][AW-1:0] lane_addr;

    // Per-lane target address, wrapping naturally at the bank size.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_addr[l] = wbase + AW'(l);
    end

    // Clear on reset, otherwise store each enabled lane.
    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    if (we[l] && lane_addr[l] == AW'(e)) mem[e] <= wdata[l];
                end
            end
        end
    end

    // Read port.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/crcreg_target.sv
// Byte-level target engine for a 64-byte register bank behind a serial bus front end.
// Assumes: start/stop/addr_match/rx_valid/tx_req are single-cycle pulses from the front end,
// at most one of them per cycle; start and stop take priority over the others.
// CRC_EN=1: pointer carries length, write staged and committed on CRC match, read ends with CRC.
// CRC_EN=0: plain incrementing byte access.
module crcreg_target #(
    parameter bit         CRC_EN      = 1'b1,
    parameter logic [6:0] TARGET_ADDR = 7'h2C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       addr_match,
    input  logic       addr_rw,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_req,
    output logic [7:0] tx_data,
    output logic       crc_err
);
    import crcreg_pkg::*;

    localparam int AW = PTR_ADDR_BITS;
    localparam int LW = LEN_BITS;
    localparam logic [7:0] WR_SEED = crc8_next(8'h00, {TARGET_ADDR, 1'b0});
    localparam logic [7:0] RD_SEED = crc8_next(8'h00, {TARGET_ADDR, 1'b1});

    phase_t                       phase;
    logic [7:0]                   ptr_byte;
    logic [AW-1:0]                cur;
    logic                         got_ptr;
    logic [2:0]                   wcnt;
    logic [2:0]                   rd_idx;
    logic [MAX_XFER-1:0][7:0]     stage;
    logic [7:0]                   crc_run;
    logic                         crc_ok;
    logic                         err_q;
    logic [7:0]                   tx_q;

    logic [AW-1:0]                ptr_addr;
    logic [2:0]                   nbytes;
    logic                         end_wr, frame_used, frame_good, commit_ok, bad_end, quiet;
    logic [7:0]                   step_out, seed_rd, step_din, rdata;
    logic [MAX_XFER-1:0]          wr_we;
    logic [AW-1:0]                wr_base;
    logic [MAX_XFER-1:0][7:0]     wr_data;

    // Pointer fields and end-of-write decisions.
    always_comb begin
        ptr_addr   = ptr_byte[AW-1:0];
        nbytes     = {1'b0, ptr_byte[7:8-LW]} + 3'd1;
        quiet      = !bus_start && !bus_stop && !addr_match;
        end_wr     = (bus_start || bus_stop) && phase == PH_WR;
        frame_used = got_ptr && wcnt != 3'd0;
        frame_good = crc_ok && wcnt == nbytes + 3'd2;
        commit_ok  = end_wr && frame_used && frame_good;
        bad_end    = end_wr && frame_used && !frame_good;
    end

    // CRC data source: outgoing register byte while reading, incoming byte otherwise.
    always_comb step_din = (phase == PH_RD) ? rdata : rx_data;

    crcreg_crc8_step u_step (.crc_in(crc_run), .data_in(step_din), .crc_out(step_out));
    crcreg_crc8_step u_seed (.crc_in(RD_SEED), .data_in(ptr_byte), .crc_out(seed_rd));

    // Write port: whole staged frame at end of write, or one byte at a time in plain mode.
    always_comb begin
        wr_we   = '0;
        wr_base = ptr_addr;
        wr_data = stage;
        if (CRC_EN) begin
            for (int l = 0; l < MAX_XFER; l++) wr_we[l] = commit_ok && (3'(l) < nbytes);
        end else begin
            wr_base    = cur;
            wr_data[0] = rx_data;
            wr_we[0]   = quiet && rx_valid && phase == PH_WR && got_ptr;
        end
    end

    crcreg_regfile #(.DEPTH(REG_DEPTH), .LANES(MAX_XFER), .DW(8)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_we), .wbase(wr_base), .wdata(wr_data),
        .raddr(cur), .rdata(rdata)
    );

    // Transaction sequencer: phase, pointer, staging, running CRC and transmit byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE; ptr_byte <= '0; cur <= '0; got_ptr <= 1'b0;
            wcnt <= '0; rd_idx <= '0; stage <= '0; crc_run <= '0;
            crc_ok <= 1'b0; err_q <= 1'b0; tx_q <= '0;
        end else begin
            if (CRC_EN && bad_end) err_q <= 1'b1;
            if (bus_start || bus_stop) begin
                phase <= PH_IDLE;
            end else if (addr_match) begin
                if (addr_rw) begin
                    phase <= PH_RD; cur <= ptr_addr; rd_idx <= '0; crc_run <= seed_rd;
                end else begin
                    phase <= PH_WR; got_ptr <= 1'b0; wcnt <= '0; crc_ok <= 1'b0; crc_run <= WR_SEED;
                end
            end else if (rx_valid && phase == PH_WR) begin
                if (!got_ptr) begin
                    got_ptr <= 1'b1; ptr_byte <= rx_data; cur <= rx_data[AW-1:0]; crc_run <= step_out;
                end else begin
                    if (wcnt < nbytes) begin
                        stage[wcnt[LW-1:0]] <= rx_data; crc_run <= step_out;
                    end else if (wcnt == nbytes) begin
                        crc_ok <= (rx_data == crc_run);
                    end
                    if (wcnt != 3'd7) wcnt <= wcnt + 3'd1;
                    cur <= cur + AW'(1);
                end
            end else if (tx_req && phase == PH_RD) begin
                if (!CRC_EN || rd_idx < nbytes) begin
                    tx_q <= rdata; crc_run <= step_out; cur <= cur + AW'(1);
                end else if (rd_idx == nbytes) begin
                    tx_q <= crc_run;
                end else begin
                    tx_q <= 8'hFF;
                end
                if (rd_idx != 3'd7) rd_idx <= rd_idx + 3'd1;
            end
        end
    end

    assign tx_data = tx_q;
    assign crc_err = err_q;

    // R9: the error flag never clears outside reset.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n) err_q |=> err_q);

    // R4/R5: a rejected frame raises the flag on the next cycle.
    p_bad_end_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (CRC_EN && bad_end) |=> crc_err);

    // R8: requests past the CRC byte send 0xFF.
    p_tail_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (CRC_EN && quiet && tx_req && phase == PH_RD && rd_idx > nbytes) |=> tx_data == 8'hFF);

    // R6: the filler byte touches neither staged data nor CRC verdict.
    p_dummy_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (CRC_EN && quiet && rx_valid && phase == PH_WR && got_ptr && wcnt > nbytes)
        |=> ($stable(stage) && $stable(crc_ok)));

    // R7: data-phase reads send the bank byte at the cursor.
    p_read_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (CRC_EN && quiet && tx_req && phase == PH_RD && rd_idx < nbytes) |=> tx_data == $past(rdata));
endmodule

// File: tb/crcreg_target_test.sv
// Scoreboard bench: driver tasks push expected transmit bytes, a monitor pops and compares.
module crcreg_target_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] TADDR = 7'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic bus_start = 0, bus_stop = 0, addr_match = 0, addr_rw = 0, rx_valid = 0, tx_req = 0;
    logic [7:0] rx_data = 8'h00;
    logic sel = 1'b0;  // 0 drives the CRC copy, 1 the plain copy
    logic [7:0] tx_c, tx_p;
    logic err_c, err_p;

    crcreg_target #(.CRC_EN(1'b1), .TARGET_ADDR(TADDR)) uut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_match(addr_match & ~sel), .addr_rw(addr_rw), .rx_valid(rx_valid & ~sel),
        .rx_data(rx_data), .tx_req(tx_req & ~sel), .tx_data(tx_c), .crc_err(err_c));

    crcreg_target #(.CRC_EN(1'b0), .TARGET_ADDR(TADDR)) uut_plain (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_match(addr_match & sel), .addr_rw(addr_rw), .rx_valid(rx_valid & sel),
        .rx_data(rx_data), .tx_req(tx_req & sel), .tx_data(tx_p), .crc_err(err_p));

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [64];
    logic [7:0] shadow_p [64];
    logic [7:0] exp_q [$];
    string tag_q [$];

    // Reference CRC: bitwise feedback form.
    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ b[i];
            r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: compare each transmitted byte against the queue head.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check8(t, sel ? tx_p : tx_c, e);
        end
    end

    task automatic do_start(); bus_start = 1; @(posedge clk); #1 bus_start = 0; endtask
    task automatic do_stop();  bus_stop = 1;  @(posedge clk); #1 bus_stop = 0;  endtask
    task automatic do_addr(input logic rw);
        addr_match = 1; addr_rw = rw; @(posedge clk); #1 addr_match = 0;
    endtask
    task automatic do_byte(input logic [7:0] b);
        rx_valid = 1; rx_data = b; @(posedge clk); #1 rx_valid = 0;
    endtask
    task automatic get_byte(input logic [7:0] exp, input string tag);
        tx_req = 1; @(posedge clk); #1 tx_req = 0;
        exp_q.push_back(exp); tag_q.push_back(tag);
    endtask

    // CRC write frame; commits to the shadow only when the frame is correct.
    task automatic crc_write(input logic [7:0] ptr, input logic [31:0] data,
                             input bit bad_crc, input bit with_dummy, input logic [7:0] dummy);
        int n = int'(ptr[7:6]) + 1;
        logic [7:0] c = ref_crc(8'h00, {TADDR, 1'b0});
        c = ref_crc(c, ptr);
        do_start(); do_addr(1'b0); do_byte(ptr);
        for (int i = 0; i < n; i++) begin
            c = ref_crc(c, data[8*i +: 8]);
            do_byte(data[8*i +: 8]);
        end
        do_byte(bad_crc ? (c ^ 8'h01) : c);
        if (with_dummy) do_byte(dummy);
        do_stop();
        if (!bad_crc && with_dummy)
            for (int i = 0; i < n; i++) shadow[6'(ptr[5:0] + 6'(i))] = data[8*i +: 8];
    endtask

    // CRC read: pointer write, repeated start, data, CRC, then extra tail bytes.
    task automatic crc_read(input logic [7:0] ptr, input int extra, input string tag);
        int n = int'(ptr[7:6]) + 1;
        logic [7:0] c = ref_crc(ref_crc(8'h00, {TADDR, 1'b1}), ptr);
        do_start(); do_addr(1'b0); do_byte(ptr);
        do_start(); do_addr(1'b1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = shadow[6'(ptr[5:0] + 6'(i))];
            c = ref_crc(c, d);
            get_byte(d, tag);
        end
        get_byte(c, {tag, " crc"});
        for (int i = 0; i < extra; i++) get_byte(8'hFF, "R8 tail after crc");
        do_stop();
    endtask

    task automatic apply_reset();
        rst_n = 0; repeat (3) @(posedge clk); #1 rst_n = 1;
        for (int i = 0; i < 64; i++) begin shadow[i] = 8'h00; shadow_p[i] = 8'h00; end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        apply_reset();
        @(negedge clk);
        check8("R9 reset tx_data", tx_c, 8'h00);
        check8("R9 reset crc_err", {7'b0, err_c}, 8'h00);

        // R1 R2 R7 R8: single byte write, read with two tail requests
        crc_write(8'h05, 32'h000000A5, 0, 1, 8'h00);
        crc_read(8'h05, 2, "R7 len1 read");
        // R3: four bytes wrapping past register 63
        crc_write({2'b11, 6'd62}, 32'h44332211, 0, 1, 8'h00);
        crc_read({2'b11, 6'd62}, 1, "R3 wrap len4");
        // R2: length codes 01 and 10
        crc_write({2'b01, 6'd10}, 32'h0000BEEF, 0, 1, 8'h00);
        crc_read({2'b01, 6'd10}, 0, "R2 len2");
        crc_write({2'b10, 6'd20}, 32'h00C0FFEE, 0, 1, 8'h00);
        crc_read({2'b10, 6'd20}, 0, "R2 len3");
        // R6: non-zero filler value
        crc_write({2'b00, 6'd30}, 32'h0000005A, 0, 1, 8'hC3);
        crc_read({2'b00, 6'd30}, 0, "R6 filler ignored");
        check8("R6 no error after filler", {7'b0, err_c}, 8'h00);
        // R10: pointer-only write then stop
        do_start(); do_addr(1'b0); do_byte({2'b01, 6'd62}); do_stop();
        check8("R10 pointer-only no error", {7'b0, err_c}, 8'h00);
        crc_read({2'b01, 6'd62}, 0, "R10 read after pointer-only");

        // R4: corrupted CRC leaves register 5 untouched and raises the flag
        crc_write(8'h05, 32'h00000011, 1, 1, 8'h00);
        check8("R4 flag on bad crc", {7'b0, err_c}, 8'h01);
        crc_read(8'h05, 0, "R4 discarded write");
        // R9: flag stays set across a good write
        crc_write(8'h06, 32'h00000066, 0, 1, 8'h00);
        check8("R9 flag sticky", {7'b0, err_c}, 8'h01);
        crc_read(8'h06, 0, "R9 good write after error");

        // R9: reset clears flag and bank
        apply_reset();
        check8("R9 flag cleared by reset", {7'b0, err_c}, 8'h00);
        crc_read(8'h05, 0, "R9 bank cleared");
        // R5: missing filler byte
        crc_write(8'h07, 32'h00000077, 0, 0, 8'h00);
        check8("R5 flag on missing filler", {7'b0, err_c}, 8'h01);
        crc_read(8'h07, 0, "R5 discarded write");

        // R11: plain copy, wrap across 63
        sel = 1'b1;
        do_start(); do_addr(1'b0); do_byte(8'h3E);
        do_byte(8'h01); do_byte(8'h02); do_byte(8'h03); do_stop();
        shadow_p[62] = 8'h01; shadow_p[63] = 8'h02; shadow_p[0] = 8'h03;
        do_start(); do_addr(1'b0); do_byte(8'h3E); do_start(); do_addr(1'b1);
        for (int i = 0; i < 4; i++) get_byte(shadow_p[6'(6'd62 + 6'(i))], "R11 plain stream");
        do_stop();
        check8("R11 plain no error", {7'b0, err_p}, 8'h00);

        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule